// File: doc/BRIEF.md
# Selective-Flag 8-bit ALU

This block is the arithmetic core of a small 8-bit processor. Each clock it takes two operands, an opcode and a 3-bit amount. It returns a combinational result with a write-enable for the register file, and it keeps a registered flag byte. Every operation changes only the flags defined for it. Logical operations touch zero and sign. Arithmetic touches zero, carry, overflow and sign. Shifts and rotates touch zero, carry and sign. The bit test touches zero alone. The remaining flags keep their previous value.

The same block evaluates the ten skip-style branch conditions against the stored flags. A branch opcode drives `run_next`, which tells the sequencer whether the following instruction executes. The decision is also recorded in the branch flag. Dedicated opcodes set or clear carry, clear overflow, and set or clear the interrupt-disable flag. Instruction fetch, decode and the register file sit outside this block.

Top module: `flag_alu`

## Requirements
- R1: After reset the flag byte is 0x10. The layout is zero bit 0, carry bit 1, overflow bit 2, sign bit 3, interrupt-disable bit 4 and branch bit 5. Bits 7:6 always read 0.
- R2: AND, OR and XOR (opcodes 1, 2, 3) produce the bitwise result with wr_en high. Zero is set when the result is 0 and sign is set from result bit 7. Carry and overflow are left unchanged.
- R3: ADD (6) and SUB (7) write a+b or a−b. Carry is the unsigned carry out for ADD and the unsigned borrow for SUB. Overflow is signed two's-complement overflow. Zero and sign come from the result.
- R4: INC (4) and DEC (5) ignore opb. INC sets overflow on 0x7F→0x80 and carry on 0xFF→0x00. DEC sets overflow on 0x80→0x7F and carry (borrow) on 0x00→0xFF.
- R5: CMP (8) updates zero, carry, overflow and sign exactly as SUB would, and keeps wr_en low.
- R6: SHL (9) and SHR (10) shift by shamt with zero fill. Carry takes the last bit shifted out. Zero and sign come from the result, and overflow is unchanged.
- R7: ROL (11) and ROR (12) rotate by shamt. Carry takes the last bit carried around, and overflow is unchanged.
- R8: A shift or rotate amount of 0 returns opa unchanged and clears carry.
- R9: BIT (13) sets zero when bit shamt of opa is 1 and clears zero otherwise. No other flag changes, and wr_en stays low.
- R10: CCF (14) clears carry, SCF (15) sets carry, COF (16) clears overflow, SIF (17) sets interrupt-disable and CIF (18) clears it. Each touches only its own flag.
- R11: Branch opcodes 19 to 28 test zero, not-zero, carry, not-carry, overflow, not-overflow, sign, not-sign, interrupt-disable and not-interrupt-disable, in that order. run_next shows the result in the same cycle. The branch flag stores it at the next edge, and no other flag changes. run_next is 0 for all other opcodes.
- R12: NOP (0) and the unused codes 29 to 31 leave all flags unchanged and keep wr_en low.
- R13: wr_en is high for opcodes 1 to 7 and 9 to 12, and low for every other opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 5 | Operation select |
| opa | input | 8 | First operand; shifted, rotated and bit-tested value |
| opb | input | 8 | Second operand |
| shamt | input | 3 | Shift/rotate amount or bit index |
| result | output | 8 | Combinational operation result |
| wr_en | output | 1 | Result should be written to the destination register |
| run_next | output | 1 | Branch condition holds; the following instruction executes |
| flags | output | 8 | Registered flag byte |

## Verification
The bench builds the block at its default 8-bit data width. At that width the amount field spans every count from 0 to 7. The signed boundaries 0x7F and 0x80 and the unsigned wrap at 0xFF and 0x00 are directly reachable. Each directed sequence first places carry and overflow in a known state. This exposes any write to a flag the operation must leave alone. All ten branch conditions are then evaluated against a single flag pattern that holds some flags true and others false.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int OP_W   = 5;
    localparam int FLAG_W = 8;

    localparam int FLAG_Z = 0;
    localparam int FLAG_C = 1;
    localparam int FLAG_O = 2;
    localparam int FLAG_S = 3;
    localparam int FLAG_I = 4;
    localparam int FLAG_B = 5;

    localparam logic [FLAG_W-1:0] FLAGS_RESET = FLAG_W'(1) << FLAG_I;

    typedef enum logic [OP_W-1:0] {
        OP_NOP = 5'd0,
        OP_AND = 5'd1,
        OP_OR  = 5'd2,
        OP_XOR = 5'd3,
        OP_INC = 5'd4,
        OP_DEC = 5'd5,
        OP_ADD = 5'd6,
        OP_SUB = 5'd7,
        OP_CMP = 5'd8,
        OP_SHL = 5'd9,
        OP_SHR = 5'd10,
        OP_ROL = 5'd11,
        OP_ROR = 5'd12,
        OP_BIT = 5'd13,
        OP_CCF = 5'd14,
        OP_SCF = 5'd15,
        OP_COF = 5'd16,
        OP_SIF = 5'd17,
        OP_CIF = 5'd18,
        OP_BZ  = 5'd19,
        OP_BNZ = 5'd20,
        OP_BC  = 5'd21,
        OP_BNC = 5'd22,
        OP_BO  = 5'd23,
        OP_BNO = 5'd24,
        OP_BS  = 5'd25,
        OP_BNS = 5'd26,
        OP_BI  = 5'd27,
        OP_BNI = 5'd28
    } alu_op_e;

endpackage

// File: rtl/flag_alu_arith.sv
module flag_alu_arith
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [DATA_W-1:0]   res,
    output logic                cf,
    output logic                of
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] opnd;
    logic              is_sub;
    logic [DATA_W:0]   ext;

    always_comb begin
        opnd   = b;
        is_sub = 1'b0;
        case (op)
            OP_INC:                 opnd = DATA_W'(1);
            OP_DEC: begin           opnd = DATA_W'(1); is_sub = 1'b1; end
            OP_SUB, OP_CMP:         is_sub = 1'b1;
            default: ;
        endcase
    end

    assign ext = {1'b0, a} + {1'b0, (is_sub ? ~opnd : opnd)} + {{DATA_W{1'b0}}, is_sub};

    always_comb begin
        res = '0;
        cf  = 1'b0;
        of  = 1'b0;
        case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_INC, OP_DEC, OP_ADD, OP_SUB, OP_CMP: begin
                res = ext[DATA_W-1:0];
                cf  = is_sub ? ~ext[DATA_W] : ext[DATA_W];
                if (is_sub)
                    of = (a[MSB] != opnd[MSB]) && (ext[MSB] != a[MSB]);
                else
                    of = (a[MSB] == opnd[MSB]) && (ext[MSB] != a[MSB]);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/flag_alu_shift.sv
module flag_alu_shift #(
    parameter int DATA_W = 8,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [1:0]          mode,
    input  logic [DATA_W-1:0]   a,
    input  logic [SH_W-1:0]     amt,
    output logic [DATA_W-1:0]   res,
    output logic                cf
);
    localparam int DW2 = 2 * DATA_W;

    logic [DW2-1:0] lin_l, lin_r, rot_l, rot_r;
    logic           zero_amt;

    assign lin_l    = {{DATA_W{1'b0}}, a} << amt;
    assign lin_r    = {a, {DATA_W{1'b0}}} >> amt;
    assign rot_l    = {a, a} << amt;
    assign rot_r    = {a, a} >> amt;
    assign zero_amt = (amt == '0);

    always_comb begin
        unique case (mode)
            2'd0: begin res = lin_l[DATA_W-1:0];   cf = lin_l[DATA_W];   end
            2'd1: begin res = lin_r[DW2-1:DATA_W]; cf = lin_r[DATA_W-1]; end
            2'd2: begin res = rot_l[DW2-1:DATA_W]; cf = rot_l[DATA_W];   end
            default: begin res = rot_r[DATA_W-1:0]; cf = rot_r[DATA_W-1]; end
        endcase
        if (zero_amt) cf = 1'b0;
    end
endmodule

// File: rtl/flag_alu_cond.sv
module flag_alu_cond
    import flag_alu_pkg::*;
(
    input  alu_op_e             op,
    input  logic [FLAG_W-1:0]   fl,
    output logic                is_branch,
    output logic                take
);
    always_comb begin
        is_branch = 1'b1;
        take      = 1'b0;
        case (op)
            OP_BZ:  take =  fl[FLAG_Z];
            OP_BNZ: take = ~fl[FLAG_Z];
            OP_BC:  take =  fl[FLAG_C];
            OP_BNC: take = ~fl[FLAG_C];
            OP_BO:  take =  fl[FLAG_O];
            OP_BNO: take = ~fl[FLAG_O];
            OP_BS:  take =  fl[FLAG_S];
            OP_BNS: take = ~fl[FLAG_S];
            OP_BI:  take =  fl[FLAG_I];
            OP_BNI: take = ~fl[FLAG_I];
            default: is_branch = 1'b0;
        endcase
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OP_W-1:0]     op_code,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    input  logic [SH_W-1:0]     shamt,
    output logic [DATA_W-1:0]   result,
    output logic                wr_en,
    output logic                run_next,
    output logic [FLAG_W-1:0]   flags
);
    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};

    alu_op_e            opc;
    logic [DATA_W-1:0]  ar_res, sh_res;
    logic               ar_cf, ar_of, sh_cf;
    logic               br_valid, br_take;
    logic [1:0]         sh_mode;
    logic [FLAG_W-1:0]  flags_q, flags_d;
    logic [OP_W-1:0]    sh_idx;

    assign opc     = alu_op_e'(op_code);
    assign sh_idx  = op_code - OP_SHL;
    assign sh_mode = sh_idx[1:0];

    flag_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .op  (opc),
        .a   (opa),
        .b   (opb),
        .res (ar_res),
        .cf  (ar_cf),
        .of  (ar_of)
    );

    flag_alu_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
        .mode (sh_mode),
        .a    (opa),
        .amt  (shamt),
        .res  (sh_res),
        .cf   (sh_cf)
    );

    flag_alu_cond u_cond (
        .op        (opc),
        .fl        (flags_q),
        .is_branch (br_valid),
        .take      (br_take)
    );

    always_comb begin
        flags_d = flags_q;
        result  = '0;
        wr_en   = 1'b0;
        case (opc)
            OP_AND, OP_OR, OP_XOR: begin
                result          = ar_res;
                wr_en           = 1'b1;
                flags_d[FLAG_Z] = (ar_res == '0);
                flags_d[FLAG_S] = ar_res[MSB];
            end
            OP_INC, OP_DEC, OP_ADD, OP_SUB, OP_CMP: begin
                result          = ar_res;
                wr_en           = (opc != OP_CMP);
                flags_d[FLAG_Z] = (ar_res == '0);
                flags_d[FLAG_C] = ar_cf;
                flags_d[FLAG_O] = ar_of;
                flags_d[FLAG_S] = ar_res[MSB];
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                result          = sh_res;
                wr_en           = 1'b1;
                flags_d[FLAG_Z] = (sh_res == '0);
                flags_d[FLAG_C] = sh_cf;
                flags_d[FLAG_S] = sh_res[MSB];
            end
            OP_BIT: flags_d[FLAG_Z] = opa[shamt];
            OP_CCF: flags_d[FLAG_C] = 1'b0;
            OP_SCF: flags_d[FLAG_C] = 1'b1;
            OP_COF: flags_d[FLAG_O] = 1'b0;
            OP_SIF: flags_d[FLAG_I] = 1'b1;
            OP_CIF: flags_d[FLAG_I] = 1'b0;
            default: if (br_valid) flags_d[FLAG_B] = br_take;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= FLAGS_RESET;
        else        flags_q <= flags_d;
    end

    assign flags    = flags_q;
    assign run_next = br_valid & br_take;

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flags[FLAG_W-1:FLAG_B+1] == '0);

    p_logic_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OP_AND || opc == OP_OR || opc == OP_XOR)
        |=> ($stable(flags[FLAG_C]) && $stable(flags[FLAG_O])));

    p_inc_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OP_INC && opa == POS_MAX) |=> flags[FLAG_O]);

    p_cmp_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OP_CMP && opa == opb) |=> (flags[FLAG_Z] && !flags[FLAG_C]));

    p_bit_test_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OP_BIT) |=> (flags[FLAG_Z] == $past(opa[shamt])
                             && flags[FLAG_W-1:1] == $past(flags[FLAG_W-1:1])));

    p_branch_record_r11: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> (flags[FLAG_B] == $past(run_next)
                      && flags[FLAG_B-1:0] == $past(flags[FLAG_B-1:0])));

    p_nop_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OP_NOP) |=> $stable(flags));
endmodule

// File: tb/flag_alu_bench.sv
module flag_alu_bench;
    import flag_alu_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_code = 5'd0;
    logic [7:0] opa = 8'h00, opb = 8'h00;
    logic [2:0] shamt = 3'd0;
    logic [7:0] result, flags;
    logic       wr_en, run_next;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    flag_alu u_flag_alu (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_code  (op_code),
        .opa      (opa),
        .opb      (opb),
        .shamt    (shamt),
        .result   (result),
        .wr_en    (wr_en),
        .run_next (run_next),
        .flags    (flags)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic issue(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [2:0] n, input logic [7:0] er, input logic ew,
                         input logic [7:0] ef, input string tag);
        op_code = op; opa = a; opb = b; shamt = n;
        #2;
        check({7'd0, wr_en}, {7'd0, ew}, {tag, " wr_en"});
        if (ew) check(result, er, {tag, " result"});
        @(posedge clk); #1;
        check(flags, ef, {tag, " flags"});
    endtask

    task automatic branch(input logic [4:0] op, input logic exp_take,
                          input logic [7:0] base, input string tag);
        op_code = op;
        #2;
        check({7'd0, run_next}, {7'd0, exp_take}, {tag, " run_next"});
        check({7'd0, wr_en}, 8'd0, {tag, " wr_en"});
        @(posedge clk); #1;
        check(flags, base | ({7'd0, exp_take} << 5), {tag, " flags"});
    endtask

    task automatic t_reset;
        check(flags, 8'h10, "R1 reset flags");
        check({7'd0, run_next}, 8'd0, "R1 run_next idle");
    endtask

    task automatic t_logic;
        issue(OP_SCF, 0, 0, 0, 0, 0, 8'h12, "R10 scf");
        issue(OP_AND, 8'hF0, 8'h0F, 0, 8'h00, 1, 8'h13, "R2 and zero");
        issue(OP_OR,  8'h80, 8'h01, 0, 8'h81, 1, 8'h1A, "R2 or sign");
        issue(OP_XOR, 8'hAA, 8'hAA, 0, 8'h00, 1, 8'h13, "R2 xor zero");
    endtask

    task automatic t_addsub;
        issue(OP_ADD, 8'h7F, 8'h01, 0, 8'h80, 1, 8'h1C, "R3 add signed ovf");
        issue(OP_ADD, 8'hFF, 8'h01, 0, 8'h00, 1, 8'h13, "R3 add carry");
        issue(OP_SUB, 8'h10, 8'h20, 0, 8'hF0, 1, 8'h1A, "R3 sub borrow");
        issue(OP_SUB, 8'h80, 8'h01, 0, 8'h7F, 1, 8'h14, "R3 sub signed ovf");
    endtask

    task automatic t_incdec;
        issue(OP_INC, 8'h7F, 8'h55, 0, 8'h80, 1, 8'h1C, "R4 inc 7f");
        issue(OP_INC, 8'hFF, 8'h55, 0, 8'h00, 1, 8'h13, "R4 inc ff");
        issue(OP_DEC, 8'h80, 8'h55, 0, 8'h7F, 1, 8'h14, "R4 dec 80");
        issue(OP_DEC, 8'h00, 8'h55, 0, 8'hFF, 1, 8'h1A, "R4 dec 00");
    endtask

    task automatic t_cmp;
        issue(OP_CMP, 8'h42, 8'h42, 0, 0, 0, 8'h11, "R5 cmp equal");
        issue(OP_CMP, 8'h01, 8'h02, 0, 0, 0, 8'h1A, "R5 cmp less");
    endtask

    task automatic t_shift;
        issue(OP_ADD, 8'h7F, 8'h01, 0, 8'h80, 1, 8'h1C, "R6 set ovf");
        issue(OP_SHL, 8'h81, 0, 3'd1, 8'h02, 1, 8'h16, "R6 shl 1");
        issue(OP_SHR, 8'h81, 0, 3'd1, 8'h40, 1, 8'h16, "R6 shr 1");
        issue(OP_SHL, 8'h40, 0, 3'd2, 8'h00, 1, 8'h17, "R6 shl 2");
        issue(OP_SHR, 8'h01, 0, 3'd3, 8'h00, 1, 8'h15, "R6 shr 3");
        issue(OP_SHL, 8'h01, 0, 3'd7, 8'h80, 1, 8'h1C, "R6 shl 7");
    endtask

    task automatic t_rotate;
        issue(OP_COF, 0, 0, 0, 0, 0, 8'h18, "R10 cof");
        issue(OP_ROL, 8'h81, 0, 3'd1, 8'h03, 1, 8'h12, "R7 rol 1");
        issue(OP_ROR, 8'h81, 0, 3'd1, 8'hC0, 1, 8'h1A, "R7 ror 1");
        issue(OP_ROL, 8'h0F, 0, 3'd4, 8'hF0, 1, 8'h18, "R7 rol 4");
        issue(OP_ROR, 8'h01, 0, 3'd7, 8'h02, 1, 8'h10, "R7 ror 7");
    endtask

    task automatic t_zero_count;
        issue(OP_SCF, 0, 0, 0, 0, 0, 8'h12, "R10 scf again");
        issue(OP_SHL, 8'hA5, 0, 3'd0, 8'hA5, 1, 8'h18, "R8 shl 0");
        issue(OP_SCF, 0, 0, 0, 0, 0, 8'h1A, "R10 scf keep sign");
        issue(OP_ROR, 8'h00, 0, 3'd0, 8'h00, 1, 8'h11, "R8 ror 0");
    endtask

    task automatic t_bit;
        issue(OP_ADD, 8'h7F, 8'h01, 0, 8'h80, 1, 8'h1C, "R9 setup");
        issue(OP_BIT, 8'h04, 8'hFF, 3'd2, 0, 0, 8'h1D, "R9 bit set");
        issue(OP_BIT, 8'h04, 8'hFF, 3'd3, 0, 0, 8'h1C, "R9 bit clear");
    endtask

    task automatic t_flag_ops;
        issue(OP_SCF, 0, 0, 0, 0, 0, 8'h1E, "R10 scf");
        issue(OP_CCF, 0, 0, 0, 0, 0, 8'h1C, "R10 ccf");
        issue(OP_COF, 0, 0, 0, 0, 0, 8'h18, "R10 cof");
        issue(OP_CIF, 0, 0, 0, 0, 0, 8'h08, "R10 cif");
        issue(OP_SIF, 0, 0, 0, 0, 0, 8'h18, "R10 sif");
    endtask

    task automatic t_branch;
        issue(OP_CIF, 0, 0, 0, 0, 0, 8'h08, "R11 cif");
        issue(OP_ADD, 8'hFF, 8'h01, 0, 8'h00, 1, 8'h03, "R11 setup");
        branch(OP_BZ,  1'b1, 8'h03, "R11 bz");
        branch(OP_BNZ, 1'b0, 8'h03, "R11 bnz");
        branch(OP_BC,  1'b1, 8'h03, "R11 bc");
        branch(OP_BNC, 1'b0, 8'h03, "R11 bnc");
        branch(OP_BO,  1'b0, 8'h03, "R11 bo");
        branch(OP_BNO, 1'b1, 8'h03, "R11 bno");
        branch(OP_BS,  1'b0, 8'h03, "R11 bs");
        branch(OP_BNS, 1'b1, 8'h03, "R11 bns");
        branch(OP_BI,  1'b0, 8'h03, "R11 bi");
        branch(OP_BNI, 1'b1, 8'h03, "R11 bni");
        issue(OP_SIF, 0, 0, 0, 0, 0, 8'h33, "R11 sif");
        branch(OP_BI,  1'b1, 8'h13, "R11 bi set");
    endtask

    task automatic t_idle;
        issue(OP_NOP, 8'hFF, 8'hFF, 3'd7, 0, 0, 8'h33, "R12 nop");
        issue(5'd31,  8'h00, 8'h00, 3'd0, 0, 0, 8'h33, "R12 unused code");
        issue(5'd29,  8'h7F, 8'h01, 3'd1, 0, 0, 8'h33, "R12 unused 29");
        check({7'd0, run_next}, 8'd0, "R13 no branch run_next");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_logic();
        t_addsub();
        t_incdec();
        t_cmp();
        t_shift();
        t_rotate();
        t_zero_count();
        t_bit();
        t_flag_ops();
        t_branch();
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule